// File: doc/BRIEF.md
# Interrupt Destination Resolver

This block sits between an interrupt routing table and a set of processor-side interrupt controllers. For each request it receives one routing entry: destination field, destination mode, delivery mode, vector and trigger mode. It also receives the number of the source pin that raised the request. The block works out which processors the destination names, using each processor's physical ID, its 8-bit logical ID and its logical-format setting (flat or cluster). It then pulses one injection strobe per chosen processor, together with the vector and trigger mode.

Fixed and external-interrupt requests reach every processor in the target set. Lowest-priority requests reach exactly one processor, chosen by a rotating pointer. Requests from pin 0 are always steered to processor 0. Delivery modes the block cannot carry are dropped, and an error pulse is raised instead. When a level-triggered injection lands on a processor that reports the same vector as still pending, a warning pulse is raised.

The result is registered: every output reflects the request presented one clock edge earlier.

Top module: `irq_dest_resolver`

## Requirements
- R1: After reset all strobes, the error pulse and the warning pulse are low, and the first lowest-priority delivery selects the lowest-indexed processor of its target set.
- R2: In physical mode (req_logical = 0), destination 0xFF selects every processor.
- R3: In physical mode, any destination other than 0xFF selects only the lowest-indexed processor whose physical ID equals it. If no physical ID equals it, no processor is selected.
- R4: In logical mode (req_logical = 1), destination 0x00 selects no processor, produces no strobe and raises no error.
- R5: In logical mode, a processor whose format input is 0 (flat) is selected when the bitwise AND of the destination and its logical ID is nonzero.
- R6: In logical mode, a processor whose format input is 1 (cluster) is selected when the upper nibble of its logical ID equals the upper nibble of the destination and the AND of the two lower nibbles is nonzero.
- R7: Delivery codes 000 (fixed) and 111 (external) raise the strobe of every selected processor one cycle after req_valid. In the same cycle inj_vector and inj_level carry the request's vector and trigger bit (1 = level).
- R8: Delivery code 001 (lowest priority) raises exactly one strobe. The search starts at the processor after the one chosen last and moves upward, wrapping, to the first selected processor. The chosen processor becomes the new "last".
- R9: A request from pin 0 with code 000, 001 or 111 and a non-empty target set raises only the strobe of processor 0. Such a request leaves the rotating pointer unchanged.
- R10: Codes 010, 011, 100, 101 and 110 with a non-empty target set raise no strobe. Instead, err_mode is high for one cycle.
- R11: An empty target set produces no strobe and no error for any delivery code.
- R12: warn_level is high in the strobe cycle when the request is level-triggered and at least one strobed processor had its cpu_vec_busy bit set with the request.
- R13: In a cycle after one without req_valid, all strobes, err_mode and warn_level are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| req_pin | input | PIN_W | Source pin number |
| req_dest | input | ID_W | Destination field |
| req_logical | input | 1 | 0 physical, 1 logical destination mode |
| req_dlv | input | 3 | Delivery mode code |
| req_vector | input | 8 | Interrupt vector |
| req_level | input | 1 | 1 level-triggered, 0 edge-triggered |
| cpu_phys_id | input | N_CPU*ID_W | Physical ID per processor, processor i at bits i*ID_W |
| cpu_log_id | input | N_CPU*ID_W | Logical ID per processor |
| cpu_cluster | input | N_CPU | Logical format per processor, 1 = cluster |
| cpu_vec_busy | input | N_CPU | Processor already holds the request's vector pending |
| inj_strobe | output | N_CPU | One-cycle injection strobe per processor |
| inj_vector | output | 8 | Vector of the last accepted request |
| inj_level | output | 1 | Trigger bit of the last accepted request |
| err_mode | output | 1 | Unsupported delivery mode pulse |
| warn_level | output | 1 | Level injection onto a pending vector |

## Verification
Two functions meet in the same cycle: the pin-0 override and the rotating lowest-priority choice. A lowest-priority request from pin 0 arrives while the pointer sits mid-rotation. The bench places such a request between ordinary lowest-priority requests and checks two things. The override strobe goes to processor 0 only. The rotation then resumes exactly where it stopped. The level warning likewise coincides with a strobe. It is provoked with busy bits on targeted and on untargeted processors and judged against which strobes were actually raised.

// File: rtl/irq_dr_pkg.sv
// Shared constants and delivery-mode type for the interrupt destination resolver.
package irq_dr_pkg;

    // Delivery mode codes carried in the routing entry
    typedef enum logic [2:0] {
        DLV_FIXED  = 3'b000,
        DLV_LOWEST = 3'b001,
        DLV_SMI    = 3'b010,
        DLV_RSV3   = 3'b011,
        DLV_NMI    = 3'b100,
        DLV_INIT   = 3'b101,
        DLV_RSV6   = 3'b110,
        DLV_EXTINT = 3'b111
    } dlv_e;

    localparam int VEC_W = 8;

    // True for codes that this block forwards to processors
    function automatic logic dlv_supported(input dlv_e m);
        return (m == DLV_FIXED) || (m == DLV_LOWEST) || (m == DLV_EXTINT);
    endfunction

endpackage

// File: rtl/irq_dr_match.sv
// Destination matcher: turns a destination field and mode into a target
// bit set over N_CPU processors.
// Assumes ID_W is even (cluster split into two equal halves) and that the
// all-ones physical ID means broadcast.
module irq_dr_match #(
    parameter int N_CPU = 4,
    parameter int ID_W  = 8
) (
    input  logic [ID_W-1:0]       dest,
    input  logic                  logical,
    input  logic [N_CPU*ID_W-1:0] phys_ids,
    input  logic [N_CPU*ID_W-1:0] log_ids,
    input  logic [N_CPU-1:0]      cluster,
    output logic [N_CPU-1:0]      target
);

    localparam int HALF_W = ID_W / 2;
    localparam logic [ID_W-1:0] BCAST = {ID_W{1'b1}};

    logic [N_CPU-1:0] phys_hit;
    logic [N_CPU-1:0] log_hit;
    logic [N_CPU-1:0] phys_first;

    // Per-processor comparators, one copy per processor
    for (genvar i = 0; i < N_CPU; i++) begin : g_cpu
        logic [ID_W-1:0] pid;
        logic [ID_W-1:0] lid;
        assign pid = phys_ids[i*ID_W +: ID_W];
        assign lid = log_ids[i*ID_W +: ID_W];
        assign phys_hit[i] = (pid == dest);
        // Flat: any common bit; cluster: same cluster and a common member bit
        assign log_hit[i] = cluster[i]
            ? ((lid[ID_W-1:HALF_W] == dest[ID_W-1:HALF_W]) &&
               (|(lid[HALF_W-1:0] & dest[HALF_W-1:0])))
            : (|(lid & dest));
    end

    // Keep only the lowest-indexed physical match
    always_comb begin
        logic found;
        found      = 1'b0;
        phys_first = '0;
        for (int i = 0; i < N_CPU; i++) begin
            if (phys_hit[i] && !found) begin
                phys_first[i] = 1'b1;
                found         = 1'b1;
            end
        end
    end

    // Select the final target set by mode
    always_comb begin
        if (!logical)
            target = (dest == BCAST) ? {N_CPU{1'b1}} : phys_first;
        else if (dest == '0)
            target = '0;
        else
            target = log_hit;
    end

endmodule

// File: rtl/irq_dr_rr.sv
// Rotating single-target picker for lowest-priority delivery.
// Holds the index of the processor chosen last; the search begins one
// above it and wraps. Assumes N_CPU >= 2.
module irq_dr_rr #(
    parameter int N_CPU = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [N_CPU-1:0] cand,
    input  logic             advance,
    output logic [N_CPU-1:0] grant
);

    localparam int IDX_W = $clog2(N_CPU);
    localparam logic [IDX_W-1:0] LAST_INIT = IDX_W'(N_CPU - 1);

    logic [IDX_W-1:0] last_q;
    logic [IDX_W-1:0] pick_idx;
    logic             pick_ok;

    // Search upward from last_q+1 with wrap for the first candidate
    always_comb begin
        int j;
        grant    = '0;
        pick_idx = last_q;
        pick_ok  = 1'b0;
        for (int k = 1; k <= N_CPU; k++) begin
            j = int'(last_q) + k;
            if (j >= N_CPU) j = j - N_CPU;
            if (cand[j] && !pick_ok) begin
                grant[j] = 1'b1;
                pick_idx = IDX_W'(j);
                pick_ok  = 1'b1;
            end
        end
    end

    // Remember the processor chosen by a completed delivery
    always_ff @(posedge clk) begin
        if (!rst_n)
            last_q <= LAST_INIT;
        else if (advance && pick_ok)
            last_q <= pick_idx;
    end

    AST_RR_ONE_GRANT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant)); // R8
    AST_RR_GRANT_FROM_CAND: assert property (@(posedge clk) disable iff (!rst_n)
        (cand != '0) |-> (grant != '0)); // R8

endmodule

// File: rtl/irq_dest_resolver.sv
// Interrupt destination resolver top.
// Resolves one routing entry per cycle into registered per-processor
// injection strobes. Pin 0 is pinned to processor 0. Unsupported delivery
// modes raise err_mode. Level injections onto busy vectors raise warn_level.
// Assumes cpu_vec_busy is valid in the same cycle as req_valid.
module irq_dest_resolver
    import irq_dr_pkg::*;
#(
    parameter int N_CPU = 4,
    parameter int ID_W  = 8,
    parameter int PIN_W = 5
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic [PIN_W-1:0]      req_pin,
    input  logic [ID_W-1:0]       req_dest,
    input  logic                  req_logical,
    input  logic [2:0]            req_dlv,
    input  logic [VEC_W-1:0]      req_vector,
    input  logic                  req_level,
    input  logic [N_CPU*ID_W-1:0] cpu_phys_id,
    input  logic [N_CPU*ID_W-1:0] cpu_log_id,
    input  logic [N_CPU-1:0]      cpu_cluster,
    input  logic [N_CPU-1:0]      cpu_vec_busy,
    output logic [N_CPU-1:0]      inj_strobe,
    output logic [VEC_W-1:0]      inj_vector,
    output logic                  inj_level,
    output logic                  err_mode,
    output logic                  warn_level
);

    localparam logic [N_CPU-1:0] CPU0_ONLY = N_CPU'(1);

    dlv_e             mode;
    logic [N_CPU-1:0] target;
    logic [N_CPU-1:0] rr_grant;
    logic             has_tgt;
    logic             from_pin0;
    logic             rr_advance;
    logic [N_CPU-1:0] strobe_d;
    logic             err_d;
    logic             warn_d;

    assign mode      = dlv_e'(req_dlv);
    assign has_tgt   = |target;
    assign from_pin0 = (req_pin == '0);

    irq_dr_match #(.N_CPU(N_CPU), .ID_W(ID_W)) u_match (
        .dest     (req_dest),
        .logical  (req_logical),
        .phys_ids (cpu_phys_id),
        .log_ids  (cpu_log_id),
        .cluster  (cpu_cluster),
        .target   (target)
    );

    // Rotation advances only on a real lowest-priority pick
    assign rr_advance = req_valid && (mode == DLV_LOWEST) && !from_pin0;

    irq_dr_rr #(.N_CPU(N_CPU)) u_rr (
        .clk     (clk),
        .rst_n   (rst_n),
        .cand    (target),
        .advance (rr_advance),
        .grant   (rr_grant)
    );

    // Choose the strobe pattern from mode, pin and target set
    always_comb begin
        strobe_d = '0;
        if (req_valid && has_tgt) begin
            unique case (mode)
                DLV_FIXED, DLV_EXTINT: strobe_d = from_pin0 ? CPU0_ONLY : target;
                DLV_LOWEST:            strobe_d = from_pin0 ? CPU0_ONLY : rr_grant;
                default:               strobe_d = '0;
            endcase
        end
    end

    // Error and warning conditions for this request
    always_comb begin
        err_d  = req_valid && has_tgt && !dlv_supported(mode);
        warn_d = req_valid && req_level && (|(strobe_d & cpu_vec_busy));
    end

    // Register the pulses
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_strobe <= '0;
            err_mode   <= 1'b0;
            warn_level <= 1'b0;
        end else begin
            inj_strobe <= strobe_d;
            err_mode   <= err_d;
            warn_level <= warn_d;
        end
    end

    // Capture vector and trigger of each accepted request
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            inj_vector <= '0;
            inj_level  <= 1'b0;
        end else if (req_valid) begin
            inj_vector <= req_vector;
            inj_level  <= req_level;
        end
    end

    AST_LOWPRI_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_dlv == 3'b001) |=> $onehot0(inj_strobe)); // R8
    AST_PIN0_ONLY_CPU0: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_pin == '0) |=> (inj_strobe[N_CPU-1:1] == '0)); // R9
    AST_ERR_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        err_mode |-> (inj_strobe == '0)); // R10
    AST_LOGICAL_ZERO_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_logical && req_dest == '0) |=> (inj_strobe == '0 && !err_mode)); // R4
    AST_WARN_WITH_LEVEL: assert property (@(posedge clk) disable iff (!rst_n)
        warn_level |-> (inj_level && inj_strobe != '0)); // R12
    AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid |=> (inj_strobe == '0 && !err_mode && !warn_level)); // R13

endmodule

// File: tb/irq_dest_resolver_tb.sv
`timescale 1ns/100ps
// Directed bench for the interrupt destination resolver.
module irq_dest_resolver_tb_top;

    localparam int N  = 4;
    localparam int IW = 8;
    localparam int PW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          req_valid = 1'b0;
    logic [PW-1:0] req_pin = '0;
    logic [IW-1:0] req_dest = '0;
    logic          req_logical = 1'b0;
    logic [2:0]    req_dlv = '0;
    logic [7:0]    req_vector = '0;
    logic          req_level = 1'b0;
    logic [N*IW-1:0] cpu_phys_id = {8'h11, 8'h12, 8'h11, 8'h10};
    logic [N*IW-1:0] cpu_log_id  = {8'h08, 8'h04, 8'h02, 8'h01};
    logic [N-1:0]  cpu_cluster = '0;
    logic [N-1:0]  cpu_vec_busy = '0;
    logic [N-1:0]  inj_strobe;
    logic [7:0]    inj_vector;
    logic          inj_level;
    logic          err_mode;
    logic          warn_level;

    int checks = 0;
    int fails  = 0;

    always #2.5 clk = ~clk;

    irq_dest_resolver #(.N_CPU(N), .ID_W(IW), .PIN_W(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_pin(req_pin),
        .req_dest(req_dest), .req_logical(req_logical), .req_dlv(req_dlv),
        .req_vector(req_vector), .req_level(req_level),
        .cpu_phys_id(cpu_phys_id), .cpu_log_id(cpu_log_id),
        .cpu_cluster(cpu_cluster), .cpu_vec_busy(cpu_vec_busy),
        .inj_strobe(inj_strobe), .inj_vector(inj_vector), .inj_level(inj_level),
        .err_mode(err_mode), .warn_level(warn_level)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // Present one request for one cycle; return at the negedge where results show
    task automatic send(input logic [PW-1:0] pin, input logic [7:0] dest,
                        input logic lg, input logic [2:0] dlv,
                        input logic [7:0] vec, input logic lvl,
                        input logic [N-1:0] busy);
        @(negedge clk);
        req_valid = 1'b1; req_pin = pin; req_dest = dest; req_logical = lg;
        req_dlv = dlv; req_vector = vec; req_level = lvl; cpu_vec_busy = busy;
        @(negedge clk);
        req_valid = 1'b0; cpu_vec_busy = '0;
    endtask

    task automatic t_reset;
        chk("R1 strobes", 32'(inj_strobe), 0);
        chk("R1 err", 32'(err_mode), 0);
        chk("R1 warn", 32'(warn_level), 0);
    endtask

    task automatic t_physical;
        send(5'd3, 8'hFF, 1'b0, 3'b000, 8'h41, 1'b0, '0);
        chk("R2 broadcast", 32'(inj_strobe), 32'hF);
        chk("R7 vector", 32'(inj_vector), 32'h41);
        chk("R7 level", 32'(inj_level), 0);
        send(5'd3, 8'h11, 1'b0, 3'b000, 8'h42, 1'b1, '0);
        chk("R3 first match", 32'(inj_strobe), 32'h2);
        chk("R7 level bit", 32'(inj_level), 1);
        send(5'd3, 8'h12, 1'b0, 3'b000, 8'h43, 1'b0, '0);
        chk("R3 single match", 32'(inj_strobe), 32'h4);
        send(5'd3, 8'h55, 1'b0, 3'b000, 8'h44, 1'b0, '0);
        chk("R3 R11 no match", 32'(inj_strobe), 0);
    endtask

    task automatic t_logical_flat;
        send(5'd4, 8'h00, 1'b1, 3'b000, 8'h50, 1'b0, '0);
        chk("R4 zero dest", 32'(inj_strobe), 0);
        chk("R4 no err", 32'(err_mode), 0);
        send(5'd4, 8'h06, 1'b1, 3'b000, 8'h51, 1'b0, '0);
        chk("R5 flat", 32'(inj_strobe), 32'h6);
        send(5'd4, 8'h09, 1'b1, 3'b111, 8'h52, 1'b0, '0);
        chk("R7 extint", 32'(inj_strobe), 32'h9);
        chk("R7 extint vector", 32'(inj_vector), 32'h52);
    endtask

    task automatic t_cluster;
        cpu_cluster = 4'hF;
        cpu_log_id  = {8'h14, 8'h21, 8'h12, 8'h11};
        send(5'd6, 8'h13, 1'b1, 3'b000, 8'h60, 1'b0, '0);
        chk("R6 cluster 1", 32'(inj_strobe), 32'h3);
        send(5'd6, 8'h21, 1'b1, 3'b000, 8'h61, 1'b0, '0);
        chk("R6 cluster 2", 32'(inj_strobe), 32'h4);
        send(5'd6, 8'h18, 1'b1, 3'b000, 8'h62, 1'b0, '0);
        chk("R6 no member", 32'(inj_strobe), 0);
        cpu_cluster = '0;
        cpu_log_id  = {8'h08, 8'h04, 8'h02, 8'h01};
    endtask

    // Rotation with a pin-0 request landing mid-sequence
    task automatic t_rotation;
        send(5'd5, 8'h0F, 1'b1, 3'b001, 8'h70, 1'b0, '0);
        chk("R1 R8 first pick", 32'(inj_strobe), 32'h1);
        send(5'd5, 8'h0F, 1'b1, 3'b001, 8'h70, 1'b0, '0);
        chk("R8 second", 32'(inj_strobe), 32'h2);
        send(5'd5, 8'h0F, 1'b1, 3'b001, 8'h70, 1'b0, '0);
        chk("R8 third", 32'(inj_strobe), 32'h4);
        send(5'd0, 8'h0F, 1'b1, 3'b001, 8'h70, 1'b0, '0);
        chk("R9 pin0 lowpri", 32'(inj_strobe), 32'h1);
        send(5'd5, 8'h0F, 1'b1, 3'b001, 8'h70, 1'b0, '0);
        chk("R9 pointer kept", 32'(inj_strobe), 32'h8);
        send(5'd5, 8'h0F, 1'b1, 3'b001, 8'h70, 1'b0, '0);
        chk("R8 wrap", 32'(inj_strobe), 32'h1);
        send(5'd5, 8'h0A, 1'b1, 3'b001, 8'h70, 1'b0, '0);
        chk("R8 skip", 32'(inj_strobe), 32'h2);
        send(5'd5, 8'h0A, 1'b1, 3'b001, 8'h70, 1'b0, '0);
        chk("R8 skip wrap", 32'(inj_strobe), 32'h8);
    endtask

    task automatic t_pin0_fixed;
        send(5'd0, 8'hFF, 1'b0, 3'b000, 8'h30, 1'b0, '0);
        chk("R9 pin0 fixed", 32'(inj_strobe), 32'h1);
        send(5'd0, 8'h04, 1'b1, 3'b111, 8'h31, 1'b0, '0);
        chk("R9 pin0 extint", 32'(inj_strobe), 32'h1);
    endtask

    task automatic t_unsupported;
        for (int m = 2; m <= 6; m++) begin
            send(5'd2, 8'hFF, 1'b0, 3'(m), 8'h20, 1'b0, '0);
            chk("R10 strobe", 32'(inj_strobe), 0);
            chk("R10 err", 32'(err_mode), 1);
        end
        send(5'd2, 8'h55, 1'b0, 3'b100, 8'h20, 1'b0, '0);
        chk("R11 empty err", 32'(err_mode), 0);
        @(negedge clk);
        chk("R10 err pulse", 32'(err_mode), 0);
    endtask

    task automatic t_warning;
        send(5'd7, 8'hFF, 1'b0, 3'b000, 8'h90, 1'b1, 4'h4);
        chk("R12 busy hit", 32'(warn_level), 1);
        send(5'd7, 8'hFF, 1'b0, 3'b000, 8'h90, 1'b0, 4'h4);
        chk("R12 edge", 32'(warn_level), 0);
        send(5'd7, 8'h03, 1'b1, 3'b000, 8'h90, 1'b1, 4'h8);
        chk("R12 untargeted busy", 32'(warn_level), 0);
        send(5'd0, 8'hFF, 1'b0, 3'b000, 8'h90, 1'b1, 4'h2);
        chk("R12 redirect busy", 32'(warn_level), 0);
    endtask

    task automatic t_idle;
        send(5'd1, 8'hFF, 1'b0, 3'b000, 8'hA0, 1'b1, 4'hF);
        @(negedge clk);
        chk("R13 strobes", 32'(inj_strobe), 0);
        chk("R13 warn", 32'(warn_level), 0);
        chk("R13 err", 32'(err_mode), 0);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_rotation();
        t_physical();
        t_logical_flat();
        t_cluster();
        t_pin0_fixed();
        t_unsupported();
        t_warning();
        t_idle();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule